// File: doc/BRIEF.md
# Parallel 8080-Style LCD Write Transmitter

This block drives a write-only parallel display bus of the 8080 kind. It controls a set of data lines, a write strobe, a data/command select line and a chip select. A transfer opens when a command word is accepted on a valid/ready input. The block sends that word on the bus, then, if asked to, switches the select line to its data level and sends a stream of parameter or pixel words taken from a second valid/ready input. The last of those words carries a flag. A one-clock done pulse closes the transfer.

Each word is right-aligned in a fixed-width container, and its byte count is programmable. The block cuts the word into bus-width beats and sends the most significant beat first. Each beat takes one write-strobe period of twice the programmed prescale, counted in input clocks. The strobe's resting level, the chip-select active level and both select-line levels are configuration inputs. Pixel words can also have each adjacent pair of bytes exchanged before they are sent. A prescale of zero, or one above the supported maximum, is refused with an error pulse.

Top module: `i80_lcd_tx`

## Requirements
- R1: A word of N bytes (byte-count input = N-1) takes ceil(8N/BUS_W) bus beats. The most significant beat is sent first, and bits above the N used bytes are driven as zero. On an 8-line bus, command 0x1234 with N=2 puts 0x12 on the lines and then 0x34.
- R2: The select line holds the command level (cfg_dc_cmd) through every command beat and the data level (cfg_dc_data) through every data beat. It changes only when a command is accepted or when the command phase ends.
- R3: In each beat the write strobe leaves its resting level for P clocks and then returns to it for P clocks, where P is the prescale latched when the command was accepted. The data lines change only on the clock where the strobe leaves rest, so data is stable for P clocks on either side of the return edge.
- R4: The strobe rests high when cfg_wr_idle_low=0 and low when cfg_wr_idle_low=1.
- R5: Chip select is at cfg_cs_active from command acceptance until done, and at the opposite level otherwise. After reset it is 1.
- R6: In the data phase, with cfg_swap=1, the bytes at positions (0,1), (2,3) and so on of each data word are exchanged before serialization. Command words are never swapped.
- R7: A command offered with prescale 0 or above PRESC_MAX is consumed with a one-clock err pulse. It causes no strobe, no chip-select activity and no done.
- R8: cmd_ready is high only while idle. dat_ready is high only between data words. Both are low during the command phase and while a word is being serialized.
- R9: done pulses for one clock at the end of the final beat: the last data word (dat_last=1), or the command when cmd_has_data=0. A command of n beats with no data raises done 2·P·n clocks after the accepting edge.
- R10: If the data stream stalls after the command, the transfer stays open with chip select active and the select line at its data level. No done appears until the flagged last word has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_presc | input | PRESC_W | Half-period of the write strobe in clocks |
| cfg_cmd_bytes_m1 | input | NB_W | Command word byte count minus one |
| cfg_dat_bytes_m1 | input | NB_W | Data word byte count minus one |
| cfg_dc_cmd | input | 1 | Select line level for the command phase |
| cfg_dc_data | input | 1 | Select line level for the data phase |
| cfg_cs_active | input | 1 | Chip-select active level |
| cfg_wr_idle_low | input | 1 | 1: strobe rests low; 0: rests high |
| cfg_swap | input | 1 | Exchange adjacent byte pairs of data words |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_word | input | WORD_W | Command word, right-aligned |
| cmd_has_data | input | 1 | A data phase follows this command |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word can be taken |
| dat_word | input | WORD_W | Parameter or pixel word, right-aligned |
| dat_last | input | 1 | Final word of the transfer |
| lcd_data | output | BUS_W | Parallel data lines |
| lcd_wr | output | 1 | Write strobe |
| lcd_dc | output | 1 | Data/command select |
| lcd_cs | output | 1 | Chip select |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Unsupported prescale pulse |

## Verification
The serializer is tried with one-, two- and four-byte words at prescales 1, 2 and 3. This separates beat ordering and beat count from strobe timing. The measured strobe width and done latency expose an off-by-one in the rate counter. A command followed by three data words, and another followed by a stalled data stream, separate the two select-line levels from each other and show that done waits for the flagged word. Swapped and unswapped pixel words sent after the same command confirm that the swap touches only the data phase. Inverted strobe and chip-select polarities, and two out-of-range prescales, test the configuration paths.

// File: rtl/i80_pkg.sv
package i80_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_DWAIT = 2'd2,
    ST_DATA  = 2'd3
  } i80_state_t;
endpackage

// File: rtl/i80_rate_gen.sv
module i80_rate_gen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PRESC_W-1:0] presc,
  output logic               mid,
  output logic               fin
);
  logic               run;
  logic               half;
  logic [PRESC_W-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      half <= 1'b0;
      tick <= '0;
    end else if (start) begin
      run  <= 1'b1;
      half <= 1'b0;
      tick <= presc - 1'b1;
    end else if (run) begin
      if (tick != '0) begin
        tick <= tick - 1'b1;
      end else if (!half) begin
        half <= 1'b1;
        tick <= presc - 1'b1;
      end else begin
        run <= 1'b0;
      end
    end
  end

  assign mid = run && (tick == '0) && !half;
  assign fin = run && (tick == '0) && half;
endmodule

// File: rtl/i80_word_ser.sv
module i80_word_ser #(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 32,
  parameter int NB_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [NB_W-1:0]   nbytes_m1,
  input  logic              swap,
  input  logic              adv,
  output logic [BUS_W-1:0]  chunk,
  output logic              last_beat
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BEAT_MAX   = WORD_W / BUS_W;
  localparam int CNT_W      = (BEAT_MAX > 1) ? $clog2(BEAT_MAX) : 1;

  logic [WORD_W-1:0] swapped, picked, masked, aligned, sreg;
  logic [CNT_W-1:0]  beats_left;
  int                nb, nbeats;

  for (genvar g = 0; g < WORD_BYTES / 2; g++) begin : g_pair
    assign swapped[16*g +: 8]   = word[16*g+8 +: 8];
    assign swapped[16*g+8 +: 8] = word[16*g +: 8];
  end
  if (WORD_BYTES % 2 == 1) begin : g_odd
    assign swapped[WORD_W-1 -: 8] = word[WORD_W-1 -: 8];
  end

  always_comb begin
    picked = swap ? swapped : word;
    nb     = int'(nbytes_m1) + 1;
    for (int i = 0; i < WORD_BYTES; i++) begin
      masked[8*i +: 8] = (i < nb) ? picked[8*i +: 8] : 8'h00;
    end
    nbeats  = (nb * 8 + BUS_W - 1) / BUS_W;
    aligned = masked << (WORD_W - nbeats * BUS_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg       <= '0;
      beats_left <= '0;
    end else if (load) begin
      sreg       <= aligned;
      beats_left <= CNT_W'(nbeats - 1);
    end else if (adv) begin
      sreg       <= sreg << BUS_W;
      beats_left <= beats_left - 1'b1;
    end
  end

  assign chunk     = sreg[WORD_W-1 -: BUS_W];
  assign last_beat = (beats_left == '0);
endmodule

// File: rtl/i80_lcd_tx.sv
module i80_lcd_tx
  import i80_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int WORD_W    = 32,
  parameter int PRESC_W   = 8,
  parameter int PRESC_MAX = 64,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int NB_W       = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic [NB_W-1:0]    cfg_cmd_bytes_m1,
  input  logic [NB_W-1:0]    cfg_dat_bytes_m1,
  input  logic               cfg_dc_cmd,
  input  logic               cfg_dc_data,
  input  logic               cfg_cs_active,
  input  logic               cfg_wr_idle_low,
  input  logic               cfg_swap,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [WORD_W-1:0]  cmd_word,
  input  logic               cmd_has_data,
  input  logic               dat_valid,
  output logic               dat_ready,
  input  logic [WORD_W-1:0]  dat_word,
  input  logic               dat_last,
  output logic [BUS_W-1:0]   lcd_data,
  output logic               lcd_wr,
  output logic               lcd_dc,
  output logic               lcd_cs,
  output logic               done,
  output logic               err
);
  i80_state_t         st;
  logic [PRESC_W-1:0] lat_presc;
  logic [NB_W-1:0]    lat_dat_m1;
  logic               lat_swap, lat_dc_data, lat_cs_active, lat_wr_idle;
  logic               lat_has_data, lat_last;

  logic               presc_ok, accept, take_dat;
  logic               ser_load, ser_adv, ser_swap, last_beat;
  logic [WORD_W-1:0]  ser_word;
  logic [NB_W-1:0]    ser_nb;
  logic               rg_start, rg_mid, rg_fin;
  logic [PRESC_W-1:0] rg_presc;

  assign presc_ok  = (cfg_presc != '0) && (int'(cfg_presc) <= PRESC_MAX);
  assign accept    = (st == ST_IDLE) && cmd_valid && presc_ok;
  assign take_dat  = (st == ST_DWAIT) && dat_valid;
  assign cmd_ready = (st == ST_IDLE);
  assign dat_ready = (st == ST_DWAIT);

  assign ser_load = accept || take_dat;
  assign ser_adv  = rg_fin && !last_beat;
  assign ser_word = accept ? cmd_word : dat_word;
  assign ser_nb   = accept ? cfg_cmd_bytes_m1 : lat_dat_m1;
  assign ser_swap = take_dat && lat_swap;
  assign rg_start = ser_load || ser_adv;
  assign rg_presc = accept ? cfg_presc : lat_presc;

  i80_word_ser #(.BUS_W(BUS_W), .WORD_W(WORD_W), .NB_W(NB_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .word(ser_word), .nbytes_m1(ser_nb),
    .swap(ser_swap), .adv(ser_adv), .chunk(lcd_data), .last_beat(last_beat)
  );

  i80_rate_gen #(.PRESC_W(PRESC_W)) u_rate (
    .clk(clk), .rst(rst), .start(rg_start), .presc(rg_presc),
    .mid(rg_mid), .fin(rg_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      lcd_wr        <= 1'b1;
      lcd_cs        <= 1'b1;
      lcd_dc        <= 1'b0;
      done          <= 1'b0;
      err           <= 1'b0;
      lat_presc     <= '0;
      lat_dat_m1    <= '0;
      lat_swap      <= 1'b0;
      lat_dc_data   <= 1'b0;
      lat_cs_active <= 1'b0;
      lat_wr_idle   <= 1'b1;
      lat_has_data  <= 1'b0;
      lat_last      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          lcd_wr <= ~cfg_wr_idle_low;
          lcd_cs <= ~cfg_cs_active;
          if (cmd_valid) begin
            if (presc_ok) begin
              lat_presc     <= cfg_presc;
              lat_dat_m1    <= cfg_dat_bytes_m1;
              lat_swap      <= cfg_swap;
              lat_dc_data   <= cfg_dc_data;
              lat_cs_active <= cfg_cs_active;
              lat_wr_idle   <= ~cfg_wr_idle_low;
              lat_has_data  <= cmd_has_data;
              lcd_cs        <= cfg_cs_active;
              lcd_dc        <= cfg_dc_cmd;
              lcd_wr        <= cfg_wr_idle_low;
              st            <= ST_CMD;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_DWAIT: begin
          if (dat_valid) begin
            lat_last <= dat_last;
            lcd_wr   <= ~lat_wr_idle;
            st       <= ST_DATA;
          end
        end
        default: begin
          if (rg_mid) lcd_wr <= lat_wr_idle;
          if (rg_fin) begin
            if (!last_beat) begin
              lcd_wr <= ~lat_wr_idle;
            end else if (st == ST_CMD && lat_has_data) begin
              st     <= ST_DWAIT;
              lcd_dc <= lat_dc_data;
            end else if (st == ST_DATA && !lat_last) begin
              st <= ST_DWAIT;
            end else begin
              st     <= ST_IDLE;
              lcd_cs <= ~lat_cs_active;
              done   <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i80_lcd_tx_chk.sv
module i80_lcd_tx_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic             dat_valid,
  input logic             dat_ready,
  input logic [BUS_W-1:0] lcd_data,
  input logic             lcd_wr,
  input logic             lcd_dc,
  input logic             lcd_cs,
  input logic             done,
  input logic             err
);
  assert_ready_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ready && dat_ready));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_ready) |=> !dat_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_release_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !$stable(lcd_cs));

  assert_data_on_launch_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(lcd_data) |-> !$stable(lcd_wr));

  assert_dc_phase_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lcd_dc) |-> (dat_ready || ($past(cmd_ready) && !cmd_ready)));

  assert_reject_idle_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> cmd_ready);
endmodule

bind i80_lcd_tx i80_lcd_tx_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/i80_lcd_tx_tb.sv
module i80_lcd_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_presc = 8'd1;
  logic [1:0]  cfg_cmd_bytes_m1 = 2'd0;
  logic [1:0]  cfg_dat_bytes_m1 = 2'd0;
  logic        cfg_dc_cmd = 1'b0;
  logic        cfg_dc_data = 1'b1;
  logic        cfg_cs_active = 1'b0;
  logic        cfg_wr_idle_low = 1'b0;
  logic        cfg_swap = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        cmd_has_data = 1'b0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [31:0] dat_word = '0;
  logic        dat_last = 1'b0;
  logic [7:0]  lcd_data;
  logic        lcd_wr, lcd_dc, lcd_cs, done, err;

  i80_lcd_tx u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_n = 0, err_n = 0, done_cyc = 0;
  int cap_n = 0, act_len = 0;
  logic idle_lvl = 1'b1, cs_act = 1'b0, prev_wr = 1'b1;
  logic [7:0] cap_data [64];
  logic       cap_dc [64];
  int         cap_len [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin done_n++; done_cyc = cyc; end
      if (err) err_n++;
      if (lcd_wr != idle_lvl) act_len++;
      else begin
        if (prev_wr != idle_lvl && lcd_cs == cs_act && cap_n < 64) begin
          cap_data[cap_n] = lcd_data;
          cap_dc[cap_n]   = lcd_dc;
          cap_len[cap_n]  = act_len;
          cap_n++;
        end
        act_len = 0;
      end
      prev_wr = lcd_wr;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(logic [31:0] w, logic has_data, output int c0);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_word = w; cmd_has_data = has_data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    c0 = cyc;
  endtask

  task automatic send_dat(logic [31:0] w, logic last);
    dat_word = w; dat_last = last; dat_valid = 1'b1;
    while (!dat_ready) @(negedge clk);
    @(negedge clk);
    dat_valid = 1'b0;
  endtask

  task automatic wait_done(int n0);
    while (done_n == n0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R5 reset cs", {31'd0, lcd_cs}, 32'd1);
    check("R4 reset wr", {31'd0, lcd_wr}, 32'd1);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R8 reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
    check("R8 reset dat_ready", {31'd0, dat_ready}, 32'd0);
  endtask

  task automatic t_cmd_only;
    int b, d, c0;
    b = cap_n; d = done_n;
    cfg_presc = 8'd1; cfg_cmd_bytes_m1 = 2'd1;
    send_cmd(32'h0000_1234, 1'b0, c0);
    wait_done(d);
    check("R1 beat count", cap_n - b, 2);
    check("R1 msb first", {24'd0, cap_data[b]}, 32'h12);
    check("R1 second beat", {24'd0, cap_data[b+1]}, 32'h34);
    check("R2 dc cmd level", {31'd0, cap_dc[b]}, 32'd0);
    check("R3 strobe width p1", cap_len[b], 1);
    check("R9 done latency", done_cyc - c0, 4);
    check("R9 single done", done_n - d, 1);
  endtask

  task automatic t_cmd_data;
    int b, d, c0;
    b = cap_n; d = done_n;
    cfg_presc = 8'd2; cfg_cmd_bytes_m1 = 2'd0; cfg_dat_bytes_m1 = 2'd1;
    send_cmd(32'hFFFF_FF2C, 1'b1, c0);
    check("R8 dat_ready low in cmd", {31'd0, dat_ready}, 32'd0);
    check("R8 cmd_ready low in cmd", {31'd0, cmd_ready}, 32'd0);
    send_dat(32'h0000_A1B2, 1'b0);
    check("R8 dat_ready low mid word", {31'd0, dat_ready}, 32'd0);
    send_dat(32'h0000_C3D4, 1'b0);
    send_dat(32'h0000_E5F6, 1'b1);
    wait_done(d);
    check("R1 beats cmd+data", cap_n - b, 7);
    check("R1 byte mask cmd", {24'd0, cap_data[b]}, 32'h2C);
    check("R2 dc cmd", {31'd0, cap_dc[b]}, 32'd0);
    check("R1 data beat a1", {24'd0, cap_data[b+1]}, 32'hA1);
    check("R1 data beat b2", {24'd0, cap_data[b+2]}, 32'hB2);
    check("R1 data beat f6", {24'd0, cap_data[b+6]}, 32'hF6);
    check("R2 dc data first", {31'd0, cap_dc[b+1]}, 32'd1);
    check("R2 dc data last", {31'd0, cap_dc[b+6]}, 32'd1);
    check("R3 strobe width p2", cap_len[b+3], 2);
    check("R10 one done after data", done_n - d, 1);
  endtask

  task automatic t_swap;
    int b, d, c0;
    b = cap_n; d = done_n;
    cfg_presc = 8'd1; cfg_cmd_bytes_m1 = 2'd1; cfg_dat_bytes_m1 = 2'd1; cfg_swap = 1'b1;
    send_cmd(32'h0000_1122, 1'b1, c0);
    send_dat(32'h0000_ABCD, 1'b1);
    wait_done(d);
    cfg_swap = 1'b0;
    check("R6 cmd unswapped", {24'd0, cap_data[b]}, 32'h11);
    check("R6 cmd unswapped 2", {24'd0, cap_data[b+1]}, 32'h22);
    check("R6 data swapped", {24'd0, cap_data[b+2]}, 32'hCD);
    check("R6 data swapped 2", {24'd0, cap_data[b+3]}, 32'hAB);
  endtask

  task automatic t_polarity;
    int b, d, c0;
    cfg_wr_idle_low = 1'b1; cfg_cs_active = 1'b1; idle_lvl = 1'b0; cs_act = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 wr rests low", {31'd0, lcd_wr}, 32'd0);
    check("R5 cs idle inverted", {31'd0, lcd_cs}, 32'd0);
    b = cap_n; d = done_n;
    cfg_presc = 8'd1; cfg_cmd_bytes_m1 = 2'd0;
    send_cmd(32'h0000_005A, 1'b0, c0);
    check("R5 cs active high", {31'd0, lcd_cs}, 32'd1);
    check("R4 wr active high", {31'd0, lcd_wr}, 32'd1);
    wait_done(d);
    check("R4 beat under low idle", {24'd0, cap_data[b]}, 32'h5A);
    check("R5 cs released", {31'd0, lcd_cs}, 32'd0);
    check("R4 wr back low", {31'd0, lcd_wr}, 32'd0);
    cfg_wr_idle_low = 1'b0; cfg_cs_active = 1'b0; idle_lvl = 1'b1; cs_act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_bad_presc;
    int b, d, e, c0;
    b = cap_n; d = done_n; e = err_n;
    cfg_presc = 8'd0;
    send_cmd(32'h0000_0077, 1'b0, c0);
    repeat (6) @(negedge clk);
    check("R7 err for zero", err_n - e, 1);
    cfg_presc = 8'd65;
    send_cmd(32'h0000_0077, 1'b0, c0);
    repeat (6) @(negedge clk);
    check("R7 err for too large", err_n - e, 2);
    check("R7 no beats", cap_n - b, 0);
    check("R7 no done", done_n - d, 0);
    check("R7 cs inactive", {31'd0, lcd_cs}, 32'd1);
    cfg_presc = 8'd1;
  endtask

  task automatic t_wide;
    int b, d, c0;
    b = cap_n; d = done_n;
    cfg_presc = 8'd3; cfg_cmd_bytes_m1 = 2'd3;
    send_cmd(32'hDEAD_BEEF, 1'b0, c0);
    wait_done(d);
    check("R1 four beats", cap_n - b, 4);
    check("R1 beat de", {24'd0, cap_data[b]}, 32'hDE);
    check("R1 beat ef", {24'd0, cap_data[b+3]}, 32'hEF);
    check("R3 strobe width p3", cap_len[b+1], 3);
    check("R9 done latency p3", done_cyc - c0, 24);
  endtask

  task automatic t_stall;
    int b, d, c0;
    b = cap_n; d = done_n;
    cfg_presc = 8'd1; cfg_cmd_bytes_m1 = 2'd0; cfg_dat_bytes_m1 = 2'd0;
    send_cmd(32'h0000_0055, 1'b1, c0);
    repeat (10) @(negedge clk);
    check("R10 no done while stalled", done_n - d, 0);
    check("R10 cs held active", {31'd0, lcd_cs}, 32'd0);
    check("R10 dc at data level", {31'd0, lcd_dc}, 32'd1);
    check("R8 dat_ready waiting", {31'd0, dat_ready}, 32'd1);
    send_dat(32'h0000_0099, 1'b1);
    wait_done(d);
    check("R10 data beat", {24'd0, cap_data[b+1]}, 32'h99);
    check("R10 done after last", done_n - d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cmd_only();
    t_cmd_data();
    t_swap();
    t_polarity();
    t_bad_presc();
    t_wide();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule